// File: doc/BRIEF.md
# Digital I/O Register Slave

This block is a 32-bit bus slave that holds the control and status registers of a five-channel digital I/O port. Three settings are stored in the slave: the per-channel direction, the per-channel line termination and two front-panel LED controls. A read of the pin-state word returns the channel levels that the pin logic presents on its input port. That pin logic also synchronizes the inputs and holds the output latch.

Three words drive that output latch. They are the direct-output word, the set-output word and the clear-output word, and none of them stores anything. A write to one of them copies the written channel bits to a data port and raises a matching write strobe for exactly one clock.

Every access is acknowledged one clock after the request. Stall stays low. The bus address counts 32-bit words, so a byte offset divided by four gives the word index.

Top module: `dio_regs_slave`

## Requirements
- R1: After reset the direction, termination and LED outputs are all zero. Ack and the three write strobes are low.
- R2: A request is a cycle with cyc and stb high while ack is low. Ack is high for exactly one clock, in the cycle after the request. Stall is always low. A master that holds stb high receives one ack every two clocks.
- R3: Word 0 holds the direction field in bits 4:0, where 1 makes a channel an output. It can be written and read back, and it drives the direction output.
- R4: A read of word 1 returns the pin-state input in bits 4:0. A write to word 1 changes nothing.
- R5: Word 3 holds the termination field in bits 4:0, where 1 enables termination on that channel. It can be written and read back, and it drives the termination output.
- R6: Word 8 holds the bottom-LED control in bit 0 and the top-LED control in bit 1. Both can be written and read back, and each drives its LED output.
- R7: A write to word 2 presents the written bits 4:0 on the direct data output and raises the direct strobe. Both appear in the ack cycle, and the strobe lasts exactly one clock.
- R8: A write to word 4 drives the set data output and set strobe, and a write to word 5 drives the clear data output and clear strobe. Both follow the timing of R7. At most one strobe is high in any cycle.
- R9: Reads of words 2, 4, 5, of the unmapped words 6, 7 and 9 to 15, and of bits 31:5 of any word return zero. Writes to unmapped words are acknowledged, pulse no strobe and change no stored field.
- R10: A write with select bit 0 low is acknowledged but has no effect on any field or strobe.
- R11: A read pulses no write strobe and leaves every stored field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAdr | input | 4 | Word address |
| busDatIn | input | 32 | Write data |
| busDatOut | output | 32 | Read data, valid while ack is high |
| busCyc | input | 1 | Bus cycle in progress |
| busStb | input | 1 | Transfer strobe |
| busWe | input | 1 | 1 for a write, 0 for a read |
| busSel | input | 4 | Byte select; bit 0 enables writes |
| busAck | output | 1 | Transfer acknowledge |
| busStall | output | 1 | Always low |
| pinStateIn | input | 5 | Synchronized channel levels |
| dirOut | output | 5 | Per-channel direction, 1 = output |
| termOut | output | 5 | Per-channel termination enable |
| ledBottom | output | 1 | Bottom LED control |
| ledTop | output | 1 | Top LED control |
| directData | output | 5 | Written value for the output latch |
| directWr | output | 1 | One-clock strobe for directData |
| setData | output | 5 | Channels to force high |
| setWr | output | 1 | One-clock strobe for setData |
| clearData | output | 5 | Channels to force low |
| clearWr | output | 1 | One-clock strobe for clearData |

## Verification
The bench sweeps every 5-bit pattern through the direction, termination, pin-state and three pass-through words. It also steps through every LED pattern. For each write it checks that the strobe is high in the ack cycle and low in the cycle after. A strobe that stretched to two clocks would make the pin logic apply a set or clear twice, and a strobe that came early would not line up with ack.

Reads of the write-only and unmapped words must come back as zero, even when stale data sits on the pass-through outputs. A write to a hole must leave every stored field untouched, which would fail if the address decode ignored the upper address bits. A held stb must give exactly one ack every two clocks. Writes with select bit 0 low, and writes to the read-only pin-state word, must leave every output unchanged.

// File: rtl/dio_regs_pkg.sv
package dio_regs_pkg;

  localparam int unsigned WORD_DIR    = 0;
  localparam int unsigned WORD_PIN    = 1;
  localparam int unsigned WORD_DIRECT = 2;
  localparam int unsigned WORD_TERM   = 3;
  localparam int unsigned WORD_SET    = 4;
  localparam int unsigned WORD_CLEAR  = 5;
  localparam int unsigned WORD_LED    = 8;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_DIR,
    RD_PIN,
    RD_TERM,
    RD_LED
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrTerm;
    logic   wrLed;
    logic   wrDirect;
    logic   wrSet;
    logic   wrClear;
    logic   rdLoad;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/dio_regs_ctrl.sv
module dio_regs_ctrl
  import dio_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] adr,
  input  logic              cyc,
  input  logic              stb,
  input  logic              we,
  input  logic              selLow,
  output ctrlStrobes_t      strobes,
  output logic              ack
);

  logic ackQ;
  logic req;
  logic wrEn;

  assign req  = cyc && stb && !ackQ;
  assign wrEn = req && we && selLow;

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_ZERO;
    strobes.rdLoad = req;
    unique case (adr)
      ADDR_W'(WORD_DIR): begin
        strobes.rdSel = RD_DIR;
        strobes.wrDir = wrEn;
      end
      ADDR_W'(WORD_PIN):    strobes.rdSel = RD_PIN;
      ADDR_W'(WORD_DIRECT): strobes.wrDirect = wrEn;
      ADDR_W'(WORD_TERM): begin
        strobes.rdSel  = RD_TERM;
        strobes.wrTerm = wrEn;
      end
      ADDR_W'(WORD_SET):   strobes.wrSet   = wrEn;
      ADDR_W'(WORD_CLEAR): strobes.wrClear = wrEn;
      ADDR_W'(WORD_LED): begin
        strobes.rdSel = RD_LED;
        strobes.wrLed = wrEn;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= req;
  end

  assign ack = ackQ;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);  // R2
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (cyc && stb && !ackQ) |=> ackQ);  // R2

endmodule

// File: rtl/dio_regs_datapath.sv
module dio_regs_datapath
  import dio_regs_pkg::*;
#(
  parameter int unsigned CHANNELS = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LEDS     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [CHANNELS-1:0] wrBits,
  input  logic [LEDS-1:0]     wrLedBits,
  input  logic [CHANNELS-1:0] pinState,
  output logic [DATA_W-1:0]   rdData,
  output logic [CHANNELS-1:0] dirQ,
  output logic [CHANNELS-1:0] termQ,
  output logic [LEDS-1:0]     ledQ,
  output logic [CHANNELS-1:0] directDataQ,
  output logic                directWrQ,
  output logic [CHANNELS-1:0] setDataQ,
  output logic                setWrQ,
  output logic [CHANNELS-1:0] clearDataQ,
  output logic                clearWrQ
);

  localparam int unsigned PASS_N = 3;

  logic [DATA_W-1:0]   rdNext;
  logic [PASS_N-1:0]   passWr;
  logic [PASS_N-1:0]   passWrQ;
  logic [CHANNELS-1:0] passDataQ [PASS_N];

  // stored fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      termQ <= '0;
      ledQ  <= '0;
    end else begin
      if (strobes.wrDir)  dirQ  <= wrBits;
      if (strobes.wrTerm) termQ <= wrBits;
      if (strobes.wrLed)  ledQ  <= wrLedBits;
    end
  end

  // pass-through words: same structure three times
  assign passWr = {strobes.wrClear, strobes.wrSet, strobes.wrDirect};

  for (genvar g = 0; g < PASS_N; g++) begin : gPass
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        passWrQ[g]   <= 1'b0;
        passDataQ[g] <= '0;
      end else begin
        passWrQ[g] <= passWr[g];
        if (passWr[g]) passDataQ[g] <= wrBits;
      end
    end
  end

  assign directWrQ   = passWrQ[0];
  assign setWrQ      = passWrQ[1];
  assign clearWrQ    = passWrQ[2];
  assign directDataQ = passDataQ[0];
  assign setDataQ    = passDataQ[1];
  assign clearDataQ  = passDataQ[2];

  // read mux, registered into the ack cycle
  always_comb begin
    rdNext = '0;
    unique case (strobes.rdSel)
      RD_DIR:  rdNext = DATA_W'(dirQ);
      RD_PIN:  rdNext = DATA_W'(pinState);
      RD_TERM: rdNext = DATA_W'(termQ);
      RD_LED:  rdNext = DATA_W'(ledQ);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.rdLoad) rdData <= rdNext;
  end

  AST_DIRECT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    directWrQ |=> !directWrQ);  // R7
  AST_SET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    setWrQ |=> !setWrQ);  // R8
  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    clearWrQ |=> !clearWrQ);  // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({directWrQ, setWrQ, clearWrQ}));  // R8
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrDir |=> $stable(dirQ));  // R3
  AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrTerm |=> $stable(termQ));  // R5
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrLed |=> $stable(ledQ));  // R6

endmodule

// File: rtl/dio_regs_slave.sv
module dio_regs_slave
  import dio_regs_pkg::*;
#(
  parameter int unsigned CHANNELS = 5,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SEL_W    = DATA_W / 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAdr,
  input  logic [DATA_W-1:0]   busDatIn,
  output logic [DATA_W-1:0]   busDatOut,
  input  logic                busCyc,
  input  logic                busStb,
  input  logic                busWe,
  input  logic [SEL_W-1:0]    busSel,
  output logic                busAck,
  output logic                busStall,
  input  logic [CHANNELS-1:0] pinStateIn,
  output logic [CHANNELS-1:0] dirOut,
  output logic [CHANNELS-1:0] termOut,
  output logic                ledBottom,
  output logic                ledTop,
  output logic [CHANNELS-1:0] directData,
  output logic                directWr,
  output logic [CHANNELS-1:0] setData,
  output logic                setWr,
  output logic [CHANNELS-1:0] clearData,
  output logic                clearWr
);

  localparam int unsigned LEDS = 2;

  ctrlStrobes_t    strobes;
  logic [LEDS-1:0] ledQ;
  logic            unusedBits;

  assign unusedBits = ^{busSel[SEL_W-1:1], busDatIn[DATA_W-1:CHANNELS]};

  dio_regs_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .adr     (busAdr),
    .cyc     (busCyc),
    .stb     (busStb),
    .we      (busWe),
    .selLow  (busSel[0]),
    .strobes (strobes),
    .ack     (busAck)
  );

  dio_regs_datapath #(
    .CHANNELS (CHANNELS),
    .DATA_W   (DATA_W),
    .LEDS     (LEDS)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrBits      (busDatIn[CHANNELS-1:0]),
    .wrLedBits   (busDatIn[LEDS-1:0]),
    .pinState    (pinStateIn),
    .rdData      (busDatOut),
    .dirQ        (dirOut),
    .termQ       (termOut),
    .ledQ        (ledQ),
    .directDataQ (directData),
    .directWrQ   (directWr),
    .setDataQ    (setData),
    .setWrQ      (setWr),
    .clearDataQ  (clearData),
    .clearWrQ    (clearWr)
  );

  assign ledBottom = ledQ[0];
  assign ledTop    = ledQ[1];
  assign busStall  = 1'b0;

  AST_STROBE_IN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (directWr || setWr || clearWr) |-> busAck);  // R7
  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    busCyc |-> !busStall);  // R2

endmodule

// File: tb/test_dio_regs_slave.sv
module test_dio_regs_slave;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAdr = '0;
  logic [31:0] busDatIn = '0;
  logic [31:0] busDatOut;
  logic        busCyc = 1'b0, busStb = 1'b0, busWe = 1'b0;
  logic [3:0]  busSel = 4'hF;
  logic        busAck, busStall;
  logic [4:0]  pinStateIn = '0;
  logic [4:0]  dirOut, termOut, directData, setData, clearData;
  logic        ledBottom, ledTop, directWr, setWr, clearWr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // samples taken in the ack cycle (a) and the cycle after (b)
  logic        ackA, ackB;
  logic [2:0]  wrA, wrB;
  logic [31:0] rdA;

  logic [4:0] expDir = '0, expTerm = '0;
  logic [1:0] expLed = '0;

  always #5 clk = ~clk;

  dio_regs_slave i_dio_regs_slave (
    .clk(clk), .rstN(rstN), .busAdr(busAdr), .busDatIn(busDatIn),
    .busDatOut(busDatOut), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busSel(busSel), .busAck(busAck), .busStall(busStall),
    .pinStateIn(pinStateIn), .dirOut(dirOut), .termOut(termOut),
    .ledBottom(ledBottom), .ledTop(ledTop), .directData(directData),
    .directWr(directWr), .setData(setData), .setWr(setWr),
    .clearData(clearData), .clearWr(clearWr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic access(input logic [3:0] adr, input logic we,
                        input logic [31:0] dat, input logic [3:0] sel);
    @(negedge clk);
    busAdr = adr; busWe = we; busDatIn = dat; busSel = sel;
    busCyc = 1'b1; busStb = 1'b1;
    @(negedge clk);
    ackA = busAck; wrA = {clearWr, setWr, directWr}; rdA = busDatOut;
    busCyc = 1'b0; busStb = 1'b0; busWe = 1'b0;
    @(negedge clk);
    ackB = busAck; wrB = {clearWr, setWr, directWr};
  endtask

  task automatic chkStored(input string tag);
    chk({tag, " dir"},  32'(dirOut), 32'(expDir));
    chk({tag, " term"}, 32'(termOut), 32'(expTerm));
    chk({tag, " led"},  32'({ledTop, ledBottom}), 32'(expLed));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dir", 32'(dirOut), 0);
    chk("R1 term", 32'(termOut), 0);
    chk("R1 led", 32'({ledTop, ledBottom}), 0);
    chk("R1 ack", 32'(busAck), 0);
    chk("R1 strobes", 32'({clearWr, setWr, directWr}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 / R5 sweeps with readback
    for (int v = 0; v < 32; v++) begin
      access(4'd0, 1'b1, 32'hFFFF_FFE0 | 32'(v), 4'hF);
      expDir = 5'(v);
      chk("R3 ack", 32'({ackA, ackB}), 32'b10);
      chk("R3 dirOut", 32'(dirOut), 32'(v));
      access(4'd0, 1'b0, 0, 4'hF);
      chk("R3 readback", rdA, 32'(v));
      chk("R11 no strobe on read", 32'({wrA, wrB}), 0);
      access(4'd3, 1'b1, 32'(31 - v), 4'hF);
      expTerm = 5'(31 - v);
      access(4'd3, 1'b0, 0, 4'hF);
      chk("R5 readback", rdA, 32'(31 - v));
      chkStored("R5");
    end

    // R6 LEDs
    for (int v = 0; v < 4; v++) begin
      access(4'd8, 1'b1, 32'hFFFF_FFFC | 32'(v), 4'hF);
      expLed = 2'(v);
      access(4'd8, 1'b0, 0, 4'hF);
      chk("R6 readback", rdA, 32'(v));
      chkStored("R6");
    end

    // R4 pin state and ignored write
    for (int v = 0; v < 32; v++) begin
      pinStateIn = 5'(v);
      access(4'd1, 1'b0, 0, 4'hF);
      chk("R4 pin read", rdA, 32'(v));
    end
    access(4'd1, 1'b1, 32'h1F, 4'hF);
    chk("R4 write no strobe", 32'({wrA, wrB}), 0);
    chkStored("R4");

    // R7 / R8 pass-through words
    for (int v = 0; v < 32; v++) begin
      access(4'd2, 1'b1, 32'(v), 4'hF);
      chk("R7 strobe", 32'({wrA, wrB}), 32'b001_000);
      chk("R7 data", 32'(directData), 32'(v));
      access(4'd4, 1'b1, 32'(v ^ 5'h15), 4'hF);
      chk("R8 set strobe", 32'({wrA, wrB}), 32'b010_000);
      chk("R8 set data", 32'(setData), 32'(v ^ 5'h15));
      access(4'd5, 1'b1, 32'(31 - v), 4'hF);
      chk("R8 clear strobe", 32'({wrA, wrB}), 32'b100_000);
      chk("R8 clear data", 32'(clearData), 32'(31 - v));
    end
    chkStored("R8");

    // R9 write-only and unmapped reads/writes
    for (int a = 2; a < 16; a++) begin
      if (a == 3 || a == 8) continue;
      access(4'(a), 1'b0, 0, 4'hF);
      chk("R9 read zero", rdA, 0);
      chk("R9 read ack", 32'(ackA), 1);
      if (a >= 6) begin
        access(4'(a), 1'b1, 32'hFFFF_FFFF, 4'hF);
        chk("R9 hole write ack", 32'(ackA), 1);
        chk("R9 hole no strobe", 32'({wrA, wrB}), 0);
        chkStored("R9");
      end
    end

    // R10 select bit 0 low
    access(4'd0, 1'b1, 32'h0A, 4'hE);
    chk("R10 ack", 32'(ackA), 1);
    access(4'd5, 1'b1, 32'h1F, 4'hE);
    chk("R10 no strobe", 32'({wrA, wrB}), 0);
    access(4'd8, 1'b1, 32'h3, 4'hE);
    chkStored("R10");

    // R2 held stb gives one ack every two clocks, stall low
    begin
      int acks = 0;
      @(negedge clk);
      busAdr = 4'd0; busWe = 1'b0; busCyc = 1'b1; busStb = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (busAck) acks++;
        chk("R2 stall low", 32'(busStall), 0);
      end
      busCyc = 1'b0; busStb = 1'b0;
      chk("R2 acks for held stb", 32'(acks), 2);
      @(negedge clk);
      chk("R2 ack drops", 32'(busAck), 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule